// File: doc/BRIEF.md
# Warp Memory Request Coalescer

This unit sits between a warp's load/store issue stage and the memory system. It takes one request per warp: a 32-bit byte address for each of the 32 lanes and a mask of the lanes that are active. It groups the active lanes by the 128-byte line their address falls in. It then sends one transaction per distinct line, carrying the line address and the lanes that transaction serves.

Transactions leave one per cycle over a valid/ready handshake. The input side drops its ready while a warp is being split and reopens once the last transaction has been taken. A unit-stride warp whose addresses stay inside one aligned line becomes a single transaction. A warp whose lanes are each a line or more apart costs one transaction for every active lane.

Top module: `warp_coalescer`

## Requirements
- R1: A transaction's line address is bits [31:7] of a lane's byte address, and every pending active lane whose address has those same bits is served by that one transaction.
- R2: When lane i reads base + 4*i, one transaction results if base is 128-byte aligned and two results if it is not. The lane masks of the two are split at the line boundary.
- R3: When every active lane falls in a different line (stride of 128 bytes or more), one transaction is emitted per active lane.
- R4: Inactive lanes appear in no lane mask. The OR of all emitted lane masks of a warp equals its active mask, and no two of them share a lane.
- R5: Transactions of a warp leave in increasing order of the lowest-numbered lane each contains.
- R6: req_ready is low from the cycle after a request with a non-zero mask is accepted until the cycle after its last transaction is accepted, and is high again then.
- R7: While txn_valid is high and txn_ready is low, txn_line and txn_lanes hold their values and no transaction is lost.
- R8: A request with an all-zero mask is accepted, produces no transaction, and leaves req_ready high.
- R9: After reset, req_ready is 1 and txn_valid is 0.
- R10: The first transaction of a warp is valid in the cycle right after the request is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A warp request is offered |
| req_ready | output | 1 | Unit can take a warp request |
| req_addr | input | 1024 | Byte address of lane i in bits [32*i+31 : 32*i] |
| req_mask | input | 32 | Active-lane mask, bit i for lane i |
| txn_valid | output | 1 | A line transaction is offered |
| txn_ready | input | 1 | Downstream takes the transaction |
| txn_line | output | 25 | Line address (byte address bits [31:7]) |
| txn_lanes | output | 32 | Lanes served by this transaction |

## Verification
The stimulus covers aligned unit stride, which must collapse to one transaction, and unaligned unit stride, which must split exactly at the line boundary. A 128-byte stride shows the one-per-lane worst case. A mixed pattern with interleaved lanes from three lines tells real line grouping apart from merging only adjacent lanes, and also checks the lowest-lane ordering. Sparse masks, an empty mask and irregular backpressure show that inactive lanes are dropped, that masks stay disjoint and complete, and that outputs hold while stalled.

// File: rtl/coal_pkg.sv
package coal_pkg;
    parameter int LANES      = 32;
    parameter int ADDR_W     = 32;
    parameter int LINE_BYTES = 128;
    localparam int OFFSET_W  = $clog2(LINE_BYTES);
    localparam int LINE_W    = ADDR_W - OFFSET_W;
    localparam int IDX_W     = $clog2(LANES);
endpackage

// File: rtl/coal_leader_pick.sv
module coal_leader_pick #(
    parameter int LANES = 32,
    parameter int IDX_W = $clog2(LANES)
) (
    input  logic [LANES-1:0] pending,
    output logic [IDX_W-1:0] leader_idx,
    output logic             any_pending
);
    always_comb begin
        leader_idx  = '0;
        any_pending = |pending;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pending[i]) leader_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/coal_line_match.sv
module coal_line_match #(
    parameter int LANES  = 32,
    parameter int LINE_W = 25
) (
    input  logic [LANES-1:0][LINE_W-1:0] lines,
    input  logic [LANES-1:0]             pending,
    input  logic [LINE_W-1:0]            key_line,
    output logic [LANES-1:0]             hit
);
    for (genvar g = 0; g < LANES; g++) begin : g_cmp
        assign hit[g] = pending[g] && (lines[g] == key_line);
    end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
    import coal_pkg::*;
#(
    parameter int P_LANES      = LANES,
    parameter int P_ADDR_W     = ADDR_W,
    parameter int P_LINE_BYTES = LINE_BYTES
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [P_LANES*P_ADDR_W-1:0]   req_addr,
    input  logic [P_LANES-1:0]            req_mask,
    output logic                          txn_valid,
    input  logic                          txn_ready,
    output logic [P_ADDR_W-$clog2(P_LINE_BYTES)-1:0] txn_line,
    output logic [P_LANES-1:0]            txn_lanes
);
    localparam int OFS_W = $clog2(P_LINE_BYTES);
    localparam int LN_W  = P_ADDR_W - OFS_W;
    localparam int IX_W  = $clog2(P_LANES);

    typedef struct packed {
        logic                          busy;
        logic [P_LANES-1:0]            pending;
        logic [P_LANES-1:0][LN_W-1:0]  lines;
    } state_t;

    state_t st_d, st_q;

    // split the flat address bus into per-lane line numbers
    logic [P_LANES-1:0][LN_W-1:0]  in_lines;
    logic [P_LANES-1:0][OFS_W-1:0] offs_unused;
    for (genvar g = 0; g < P_LANES; g++) begin : g_split
        assign in_lines[g]    = req_addr[g*P_ADDR_W+OFS_W +: LN_W];
        assign offs_unused[g] = req_addr[g*P_ADDR_W +: OFS_W];
    end
    logic sink_unused;
    assign sink_unused = ^offs_unused;

    logic [IX_W-1:0] leader_idx;
    logic            any_pending;
    logic [LN_W-1:0] leader_line;
    logic [P_LANES-1:0] group;

    coal_leader_pick #(.LANES(P_LANES), .IDX_W(IX_W)) pick_i (
        .pending     (st_q.pending),
        .leader_idx  (leader_idx),
        .any_pending (any_pending)
    );

    assign leader_line = st_q.lines[leader_idx];

    coal_line_match #(.LANES(P_LANES), .LINE_W(LN_W)) match_i (
        .lines    (st_q.lines),
        .pending  (st_q.pending),
        .key_line (leader_line),
        .hit      (group)
    );

    assign req_ready = !st_q.busy;
    assign txn_valid = st_q.busy && any_pending;
    assign txn_line  = leader_line;
    assign txn_lanes = group;

    always_comb begin
        logic [P_LANES-1:0] left;
        st_d = st_q;
        left = st_q.pending & ~group;
        if (req_valid && !st_q.busy) begin
            st_d.lines   = in_lines;
            st_d.pending = req_mask;
            st_d.busy    = |req_mask;
        end else if (txn_valid && txn_ready) begin
            st_d.pending = left;
            st_d.busy    = |left;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/warp_coalescer_checker.sv
module warp_coalescer_checker #(
    parameter int LANES  = 32,
    parameter int LINE_W = 25
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [LANES-1:0]  req_mask,
    input logic              txn_valid,
    input logic              txn_ready,
    input logic [LINE_W-1:0] txn_line,
    input logic [LANES-1:0]  txn_lanes
);
    // R6: input side closed while transactions are outstanding
    a_r6_closed_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> !req_ready);

    // R10: non-empty warp accepted gives a transaction next cycle
    a_r10_first_txn: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_mask != '0)) |=> txn_valid);

    // R8: empty warp leaves input open
    a_r8_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_mask == '0)) |=> (req_ready && !txn_valid));

    // R4: every transaction serves at least one lane
    a_r4_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> (txn_lanes != '0));

    // R7: hold under backpressure
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_line) && $stable(txn_lanes)));

    // R4: successive transactions of a warp share no lane
    a_r4_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_ready) |=> (!txn_valid || ((txn_lanes & $past(txn_lanes)) == '0)));

    // R5: next transaction holds no lane below the previous lowest lane
    a_r5_order: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_ready) |=> (!txn_valid ||
            ((txn_lanes & (($past(txn_lanes) & (~$past(txn_lanes) + 1'b1)) - 1'b1)) == '0)));
endmodule

bind warp_coalescer warp_coalescer_checker #(.LANES(P_LANES), .LINE_W(LN_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_mask  (req_mask),
    .txn_valid (txn_valid),
    .txn_ready (txn_ready),
    .txn_line  (txn_line),
    .txn_lanes (txn_lanes)
);

// File: tb/warp_coalescer_tb.sv
module warp_coalescer_tb_top;
    localparam int L  = 32;
    localparam int AW = 32;
    localparam int LW = 25;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [L*AW-1:0] req_addr = '0;
    logic [L-1:0] req_mask = '0;
    logic txn_valid;
    logic txn_ready = 1'b0;
    logic [LW-1:0] txn_line;
    logic [L-1:0] txn_lanes;

    int n_chk = 0;
    int n_bad = 0;

    logic [AW-1:0] addr_a [L];
    logic [LW-1:0] got_line [L+1];
    logic [L-1:0]  got_lanes [L+1];
    int            n_got;

    always #4 clk = ~clk;

    warp_coalescer dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_mask(req_mask), .txn_valid(txn_valid),
        .txn_ready(txn_ready), .txn_line(txn_line), .txn_lanes(txn_lanes)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // issue one warp; stall_pat bit k low means stall in service cycle k
    task automatic run_warp(input logic [L-1:0] mask, input logic [31:0] stall_pat, input string tag);
        int cyc;
        logic [LW-1:0] hl;
        logic [L-1:0]  hm;
        logic held;
        @(negedge clk);
        for (int i = 0; i < L; i++) req_addr[i*AW +: AW] = addr_a[i];
        req_mask  = mask;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (mask != '0) begin
            check({tag, " R10 txn_valid after accept"}, 64'(txn_valid), 64'd1);
            check({tag, " R6 req_ready low"}, 64'(req_ready), 64'd0);
        end else begin
            check({tag, " R8 no txn on empty mask"}, 64'(txn_valid), 64'd0);
            check({tag, " R8 req_ready stays high"}, 64'(req_ready), 64'd1);
        end
        n_got = 0; cyc = 0; held = 1'b0; hl = '0; hm = '0;
        while (txn_valid && cyc < 200) begin
            if (held) begin
                check({tag, " R7 line held"}, 64'(txn_line), 64'(hl));
                check({tag, " R7 lanes held"}, 64'(txn_lanes), 64'(hm));
            end
            txn_ready = stall_pat[cyc % 32];
            if (txn_ready) begin
                if (n_got <= L) begin
                    got_line[n_got]  = txn_line;
                    got_lanes[n_got] = txn_lanes;
                end
                n_got++;
                held = 1'b0;
            end else begin
                held = 1'b1; hl = txn_line; hm = txn_lanes;
            end
            cyc++;
            @(negedge clk);
            txn_ready = 1'b0;
        end
        check({tag, " R6 req_ready back high"}, 64'(req_ready), 64'd1);
        check({tag, " R9/R6 txn_valid idle"}, 64'(txn_valid), 64'd0);
    endtask

    // expected grouping computed from R1/R4/R5
    task automatic verify(input logic [L-1:0] mask, input int exp_cnt, input string tag);
        logic [L-1:0] left;
        logic [L-1:0] grp;
        logic [L-1:0] acc;
        logic [LW-1:0] ln;
        int k;
        left = mask; k = 0; acc = '0;
        check({tag, " R1/R2/R3 transaction count"}, 64'(n_got), 64'(exp_cnt));
        for (int i = 0; i < L; i++) begin
            if (left[i]) begin
                ln = addr_a[i][31:7];
                grp = '0;
                for (int j = 0; j < L; j++)
                    if (left[j] && addr_a[j][31:7] == ln) grp[j] = 1'b1;
                left &= ~grp;
                if (k < n_got && k <= L) begin
                    check({tag, " R1 line address"}, 64'(got_line[k]), 64'(ln));
                    check({tag, " R5/R1 lane mask in order"}, 64'(got_lanes[k]), 64'(grp));
                    check({tag, " R4 no overlap"}, 64'(acc & got_lanes[k]), 64'd0);
                    acc |= got_lanes[k];
                end
                k++;
            end
        end
        check({tag, " R4 union equals mask"}, 64'(acc), 64'(mask));
    endtask

    task automatic t_aligned_unit;
        for (int i = 0; i < L; i++) addr_a[i] = 32'h0001_0000 + 32'(4*i);
        run_warp('1, '1, "aligned");
        verify('1, 1, "aligned R2");
    endtask

    task automatic t_unaligned_unit;
        for (int i = 0; i < L; i++) addr_a[i] = 32'h0002_0040 + 32'(4*i);
        run_warp('1, 32'hAAAA_AAAA, "unaligned");
        verify('1, 2, "unaligned R2");
        check("unaligned R2 low half", 64'(got_lanes[0]), 64'h0000_FFFF);
    endtask

    task automatic t_stride;
        for (int i = 0; i < L; i++) addr_a[i] = 32'h0010_0000 + 32'(128*i);
        run_warp('1, 32'hDB6D_B6DB, "stride");
        verify('1, 32, "stride R3");
    endtask

    task automatic t_sparse_stride;
        logic [L-1:0] m;
        m = 32'h8421_0F01;
        for (int i = 0; i < L; i++) addr_a[i] = 32'h0030_0000 + 32'(512*i);
        run_warp(m, '1, "sparse");
        verify(m, $countones(m), "sparse R3 R4");
    endtask

    task automatic t_mixed;
        logic [L-1:0] m;
        m = 32'h7FFF_FFFE;
        for (int i = 0; i < L; i++)
            addr_a[i] = 32'h0040_0000 + 32'((2 - (i % 3)) * 128) + 32'(4*(i % 7));
        run_warp(m, 32'h3333_3333, "mixed");
        verify(m, 3, "mixed R1 R5");
    endtask

    task automatic t_empty;
        for (int i = 0; i < L; i++) addr_a[i] = 32'(i);
        run_warp('0, '1, "empty");
        verify('0, 0, "empty R8");
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset req_ready", 64'(req_ready), 64'd1);
        check("R9 reset txn_valid", 64'(txn_valid), 64'd0);
        t_aligned_unit();
        t_unaligned_unit();
        t_stride();
        t_sparse_stride();
        t_mixed();
        t_empty();
        t_aligned_unit();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule